// File: doc/BRIEF.md
# Timer Control Register Bank

This block holds the global control state of a multi-channel timer unit. It has four 32-bit registers: counter enable, clock stop, interrupt flag and interrupt mask. Each register has a read-only address, and software changes it through two atomic aliases. One alias sets every bit written as one and the other clears every bit written as one. Bits written as zero are left alone, so separate software agents can change different channels without a read-modify-write.

The counting channels send full-match and half-match event pulses, which the bank latches as flags. The full-match flag of channel n is at bit n and the half-match flag is at bit n+16. The mask register uses the same layout, and a one in the mask blocks that flag. The per-channel enable and stop bits drive the channels. Stop bit 16 gates the watchdog clock. A single interrupt request is raised while any unmasked flag is one.

The bus is word addressed: `bus_addr` is the byte offset divided by four.

Top module: `tmr_ctrl_bank`

## Requirements
- R1: After reset, ch_enable is all zeros. ch_stop is all ones and wdt_stop is one. The flag register reads zero and the mask register reads with every implemented bit one, so irq is low.
- R2: A write to word 5 (byte 0x14) sets each enable bit written as one. A write to word 6 (byte 0x18) clears each enable bit written as one. Bits written as zero keep their value. The register reads at word 4 (byte 0x10), and ch_enable shows bit n for channel n from the cycle after the write.
- R3: The stop register reads at word 7 (byte 0x1C). It is set through word 11 (byte 0x2C) and cleared through word 15 (byte 0x3C). Bit n drives ch_stop for channel n, and bit 16 drives wdt_stop. A one means the clock is halted.
- R4: The flag register reads at word 8 (byte 0x20), with its set alias at word 9 (0x24) and its clear alias at word 10 (0x28). The mask register reads at word 12 (0x30), with its set alias at word 13 (0x34) and its clear alias at word 14 (0x38).
- R5: A pulse on evt_full[n] sets flag bit n, and a pulse on evt_half[n] sets flag bit n+16. The flag is readable and acts on irq from the cycle after the pulse.
- R6: When an event pulse and a flag-clear write for the same bit fall in the same cycle, the bit ends up one. Other bits named in that clear write still clear.
- R7: irq is high exactly while some bit of (flag AND NOT mask) is one. It changes in the same cycle as the register that causes the change.
- R8: Writes to the four read addresses, or to any unmapped address (for example word 16), change nothing. A read of an alias address or an unmapped address returns zero.
- R9: bus_rdata is loaded on the clock edge that samples bus_rd and holds until the next read. Bits with no channel behind them (enable bits at or above NUM_CH, for instance) always read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_full | input | NUM_CH | Full-match event pulses, one per channel |
| evt_half | input | NUM_CH | Half-match event pulses, one per channel |
| ch_enable | output | NUM_CH | Counter enable per channel |
| ch_stop | output | NUM_CH | Clock stop per channel |
| wdt_stop | output | 1 | Watchdog clock stop |
| irq | output | 1 | Combined interrupt request |

## Verification
A write or an event pulse lands on the next rising edge. From that edge on, ch_enable, ch_stop, wdt_stop and irq show the new state, with no extra stage for irq. A read returns its data on the edge that samples the strobe. The bench drives every strobe and pulse on a falling edge and lifts it on the next falling edge, then samples the outputs there, half a period after the edge that made the change. The same-cycle race case drives the event and the clear write inside that single window, so both reach the same edge.

// File: rtl/tcrb_pkg.sv
package tcrb_pkg;

   // Register identifiers; the index also selects the read mux input.
   typedef enum logic [1:0] {
      RG_EN   = 2'd0,
      RG_STOP = 2'd1,
      RG_FLAG = 2'd2,
      RG_MASK = 2'd3
   } reg_id_e;

   localparam int NUM_REGS = 4;
   localparam int DW       = 32;
   localparam int HALF_OFS = 16;  // half-match bits start here
   localparam int WDT_BIT  = 16;  // watchdog bit in the stop register

   // Byte offsets (software visible).
   function automatic int rd_off(input int id);
      case (id)
         0:       return 'h10;
         1:       return 'h1C;
         2:       return 'h20;
         default: return 'h30;
      endcase
   endfunction

   function automatic int set_off(input int id);
      case (id)
         0:       return 'h14;
         1:       return 'h2C;
         2:       return 'h24;
         default: return 'h34;
      endcase
   endfunction

   function automatic int clr_off(input int id);
      case (id)
         0:       return 'h18;
         1:       return 'h3C;
         2:       return 'h28;
         default: return 'h38;
      endcase
   endfunction

   function automatic logic [DW-1:0] low_mask(input int nch);
      return (DW'(1) << nch) - DW'(1);
   endfunction

   // Bits that hold state for a register with nch channels.
   function automatic logic [DW-1:0] impl_mask(input int id, input int nch);
      case (id)
         0:       return low_mask(nch);
         1:       return low_mask(nch) | (DW'(1) << WDT_BIT);
         default: return low_mask(nch) | (low_mask(nch) << HALF_OFS);
      endcase
   endfunction

   // Reset value: stop and mask come up all ones, others zero.
   function automatic logic [DW-1:0] rst_val(input int id, input int nch);
      case (id)
         1:       return impl_mask(id, nch);
         3:       return impl_mask(id, nch);
         default: return '0;
      endcase
   endfunction

endpackage

// File: rtl/tcrb_decode.sv
module tcrb_decode
   import tcrb_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   output logic [NUM_REGS-1:0] set_hit,
   output logic [NUM_REGS-1:0] clr_hit,
   output logic              rd_hit,
   output logic [1:0]        rd_id
);

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_wdec
      localparam logic [ADDR_W-1:0] SET_W = ADDR_W'(set_off(g) >> 2);
      localparam logic [ADDR_W-1:0] CLR_W = ADDR_W'(clr_off(g) >> 2);
      assign set_hit[g] = wr && (addr == SET_W);
      assign clr_hit[g] = wr && (addr == CLR_W);
   end

   always_comb begin
      rd_hit = 1'b0;
      rd_id  = 2'd0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd && (addr == ADDR_W'(rd_off(i) >> 2))) begin
            rd_hit = 1'b1;
            rd_id  = 2'(i);
         end
      end
   end

   // A write reaches at most one alias
   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({set_hit, clr_hit})); // R8

   // Without a write strobe no alias fires
   AST_NO_WR_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |-> (set_hit == '0 && clr_hit == '0)); // R8

endmodule

// File: rtl/tcrb_screg.sv
module tcrb_screg #(
   parameter int          W    = 32,
   parameter logic [W-1:0] RST  = '0,
   parameter logic [W-1:0] IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_w,
   input  logic [W-1:0] clr_w,
   input  logic [W-1:0] hw_set,
   output logic [W-1:0] q
);

   // Hardware set is ORed in after the clear, so an event wins a race.
   always_ff @(posedge clk) begin
      if (!rst_n) q <= RST & IMPL;
      else        q <= ((q & ~clr_w) | set_w | hw_set) & IMPL;
   end

   AST_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_w) |=> ((q & $past(set_w & IMPL)) == $past(set_w & IMPL))); // R2

   AST_SW_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_w) |=> ((q & $past(clr_w & ~hw_set & ~set_w)) == '0)); // R2

   AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|hw_set) |=> ((q & $past(hw_set & IMPL)) == $past(hw_set & IMPL))); // R6

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (set_w == '0 && clr_w == '0 && hw_set == '0) |=> $stable(q)); // R8

   always_comb begin
      if (rst_n) AST_UNIMPL_ZERO: assert ((q & ~IMPL) == '0); // R9
   end

endmodule

// File: rtl/tcrb_irq.sv
module tcrb_irq #(
   parameter int W = 32
) (
   input  logic [W-1:0] flag,
   input  logic [W-1:0] mask,
   output logic         irq
);

   logic [W-1:0] pend;

   for (genvar b = 0; b < W; b++) begin : g_pend
      assign pend[b] = flag[b] & ~mask[b];
   end

   assign irq = |pend;

endmodule

// File: rtl/tmr_ctrl_bank.sv
module tmr_ctrl_bank
   import tcrb_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic [NUM_CH-1:0] evt_full,
   input  logic [NUM_CH-1:0] evt_half,
   output logic [NUM_CH-1:0] ch_enable,
   output logic [NUM_CH-1:0] ch_stop,
   output logic              wdt_stop,
   output logic              irq
);

   localparam logic [ADDR_W-1:0] STOP_SET_W = ADDR_W'(set_off(1) >> 2);
   localparam logic [DW-1:0]     MASK_IMPL  = impl_mask(3, NUM_CH);

   // Elaboration checks
   if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_nch
      $error("tmr_ctrl_bank: NUM_CH must be 1..16");
   end
   if (ADDR_W < 4) begin : g_bad_aw
      $error("tmr_ctrl_bank: ADDR_W must reach word 15");
   end

   logic [NUM_REGS-1:0] set_hit, clr_hit;
   logic                rd_hit;
   logic [1:0]          rd_id;
   logic [DW-1:0]       q_arr [NUM_REGS];
   logic [DW-1:0]       evt_vec;

   tcrb_decode #(.ADDR_W(ADDR_W)) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (bus_wr),
      .rd      (bus_rd),
      .addr    (bus_addr),
      .set_hit (set_hit),
      .clr_hit (clr_hit),
      .rd_hit  (rd_hit),
      .rd_id   (rd_id)
   );

   assign evt_vec = DW'(evt_full) | (DW'(evt_half) << HALF_OFS);

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [DW-1:0] set_v, clr_v, hw_v;
      assign set_v = set_hit[g] ? bus_wdata : '0;
      assign clr_v = clr_hit[g] ? bus_wdata : '0;
      if (g == int'(RG_FLAG)) begin : g_hw
         assign hw_v = evt_vec;
      end else begin : g_nohw
         assign hw_v = '0;
      end
      tcrb_screg #(
         .W    (DW),
         .RST  (rst_val(g, NUM_CH)),
         .IMPL (impl_mask(g, NUM_CH))
      ) u_r (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_w  (set_v),
         .clr_w  (clr_v),
         .hw_set (hw_v),
         .q      (q_arr[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_hit ? q_arr[rd_id] : '0;
   end

   tcrb_irq #(.W(DW)) u_irq (
      .flag (q_arr[RG_FLAG]),
      .mask (q_arr[RG_MASK]),
      .irq  (irq)
   );

   assign ch_enable = q_arr[RG_EN][NUM_CH-1:0];
   assign ch_stop   = q_arr[RG_STOP][NUM_CH-1:0];
   assign wdt_stop  = q_arr[RG_STOP][WDT_BIT];

   AST_RD_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !rd_hit) |=> (bus_rdata == '0)); // R8

   AST_WDT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == STOP_SET_W && bus_wdata[WDT_BIT]) |=> wdt_stop); // R3

   AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (q_arr[RG_MASK] == MASK_IMPL) |-> !irq); // R7

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata)); // R9

endmodule

// File: tb/sim_tmr_ctrl_bank.sv
`timescale 1ns/1ps
module sim_tmr_ctrl_bank;
   localparam int NCH = 8;
   localparam int AW  = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            bus_wr = 1'b0, bus_rd = 1'b0;
   logic [AW-1:0]   bus_addr = '0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic [NCH-1:0]  evt_full = '0, evt_half = '0;
   logic [NCH-1:0]  ch_enable, ch_stop;
   logic            wdt_stop, irq;

   int n_chk = 0, n_fail = 0;
   logic [31:0] m_en, m_stop, m_flag, m_mask;

   always #2 clk = ~clk;  // 250 MHz

   tmr_ctrl_bank #(.NUM_CH(NCH), .ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .evt_full(evt_full), .evt_half(evt_half), .ch_enable(ch_enable),
      .ch_stop(ch_stop), .wdt_stop(wdt_stop), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Strobes are raised on a falling edge and dropped on the next one.
   task automatic wr(input int byte_ofs, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = AW'(byte_ofs >> 2); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input int byte_ofs, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = AW'(byte_ofs >> 2);
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic chk_all(input string tag);
      logic [31:0] v;
      rd('h10, v); chk({tag, " en"},   v, m_en);
      rd('h1C, v); chk({tag, " stop"}, v, m_stop);
      rd('h20, v); chk({tag, " flag"}, v, m_flag);
      rd('h30, v); chk({tag, " mask"}, v, m_mask);
      chk({tag, " ch_enable"}, 32'(ch_enable), m_en & 32'hFF);
      chk({tag, " ch_stop"},   32'(ch_stop),   m_stop & 32'hFF);
      chk({tag, " wdt_stop"},  32'(wdt_stop),  32'(m_stop[16]));
      chk({tag, " irq R7"},    32'(irq),       32'(|(m_flag & ~m_mask)));
   endtask

   task automatic t_reset();
      m_en = 0; m_stop = 32'h0001_00FF; m_flag = 0; m_mask = 32'h00FF_00FF;
      chk_all("R1 reset");
   endtask

   task automatic t_enable();
      wr('h14, 32'h0000_00A5); m_en = 32'hA5;
      chk("R2 en after set", 32'(ch_enable), 32'hA5);
      wr('h14, 32'h0000_000F); m_en = 32'hAF;
      wr('h18, 32'h0000_0081); m_en = 32'h2E;
      wr('h14, 32'hFFFF_FF00);  // R9 unimplemented bits ignored
      chk_all("R2 R9 enable");
   endtask

   task automatic t_stop();
      wr('h3C, 32'h0001_0003); m_stop = 32'h0000_00FC;
      chk("R3 wdt run", 32'(wdt_stop), 0);
      chk_all("R3 stop clr");
      wr('h2C, 32'h0001_0001); m_stop = 32'h0001_00FD;
      chk_all("R3 stop set");
   endtask

   task automatic t_flag_mask();
      wr('h38, 32'h0000_0001); m_mask = 32'h00FF_00FE;
      chk("R7 no flag no irq", 32'(irq), 0);
      wr('h24, 32'h0000_0001); m_flag = 32'h1;
      chk("R4 R7 irq up", 32'(irq), 1);
      wr('h28, 32'h0000_0001); m_flag = 0;
      chk("R4 R7 irq down", 32'(irq), 0);
      wr('h24, 32'h0000_0001); m_flag = 32'h1;
      wr('h34, 32'h0000_0001); m_mask = 32'h00FF_00FF;
      chk("R4 R7 masked", 32'(irq), 0);
      chk_all("R4 flag mask");
   endtask

   task automatic t_events();
      @(negedge clk);
      evt_full = 8'h04; evt_half = 8'h80;
      @(negedge clk);
      evt_full = 0; evt_half = 0;
      m_flag = 32'h0080_0005;
      chk("R5 masked irq", 32'(irq), 0);
      wr('h38, 32'h0080_0000); m_mask = 32'h007F_00FF;
      chk("R5 R7 half irq", 32'(irq), 1);
      chk_all("R5 events");
   endtask

   task automatic t_race();
      wr('h24, 32'h0000_0004); // bit2 already set; bit1 set by event below
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = AW'('h28 >> 2); bus_wdata = 32'h0000_0006;
      evt_full = 8'h02;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = 0; evt_full = 0;
      m_flag = 32'h0080_0003;
      chk_all("R6 race");
   endtask

   task automatic t_ignored();
      logic [31:0] v;
      wr('h10, 32'hFFFF_FFFF);
      wr('h1C, 32'h0000_0000);
      wr('h20, 32'hFFFF_FFFF);
      wr('h30, 32'h0000_0000);
      wr('h40, 32'hFFFF_FFFF);
      chk_all("R8 plain writes");
      rd('h14, v); chk("R8 alias read", v, 0);
      rd('h40, v); chk("R8 unmapped read", v, 0);
      // R9 data holds after strobe drops
      rd('h1C, v);
      @(negedge clk); @(negedge clk);
      chk("R9 rdata hold", bus_rdata, m_stop);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_enable();
      t_stop();
      t_flag_mask();
      t_events();
      t_race();
      t_ignored();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule